// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit processor with fixed four-byte instructions fetches next. Each cycle, decode hands it the current fetch address, a flow-kind code, two register operands, the 16-bit branch displacement, the 26-bit jump field and a jump-register value. One clock later the unit presents the next fetch address, a flag saying that control flow left the straight-line path, and a write enable with the return address that the register file stores into register 31 for linking operations.

The compare and the branch decision are fused, so no separate compare instruction is involved. Two-operand equality tests, four tests of one operand against zero, two linking zero tests, a direct jump, a linking direct jump and a register-indirect jump are covered. Direct jump targets keep the 256 MB region of the sequential address and replace the rest with the jump field. Fetch, hazards and delay slots belong to the surrounding pipeline.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after, out_valid, npc_o, taken_o, link_we_o and link_val_o are all zero.
- R2: Results appear exactly one clock after in_valid is sampled high. out_valid mirrors in_valid with one cycle of delay. When out_valid is low, taken_o and link_we_o are low.
- R3: For a not-taken operation, and for kind codes 0 (sequential) and 12 to 15 (unused), npc_o is pc_i + 4 modulo 2^32 and taken_o is 0.
- R4: Kind 1 redirects when opa_i equals opb_i. Kind 2 redirects when they differ.
- R5: Kinds 3, 4, 5 and 6 redirect when opa_i, read as two's complement, is less than or equal to zero, greater than zero, less than zero, or greater than or equal to zero respectively.
- R6: A taken branch (kinds 1 to 8) goes to pc_i + 4 + (sign-extended boff_i shifted left by 2), modulo 2^32.
- R7: Kind 7 (less than zero) and kind 8 (greater or equal to zero) branch like kinds 5 and 6 and raise link_we_o only when taken. link_we_o is never high with taken_o low.
- R8: Kind 9 (jump) and kind 10 (jump and link) always redirect to {(pc_i+4)[31:28], jfield_i, 2'b00}. Kind 10 always raises link_we_o.
- R9: Kind 11 always redirects to jreg_i unchanged and never raises link_we_o.
- R10: Whenever out_valid is high, link_val_o equals the sampled pc_i + 4, the return address for register 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| pc_i | input | 32 | Address of the current instruction |
| kind_i | input | 4 | Flow-kind code (see requirements) |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| boff_i | input | 16 | Branch displacement in words |
| jfield_i | input | 26 | Direct jump word-address field |
| jreg_i | input | 32 | Jump-register target |
| out_valid | output | 1 | Result valid |
| npc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Write link_val_o into register 31 |
| link_val_o | output | 32 | Return address |

## Verification
The bench aims at the sign boundary of the zero tests: operands of zero, minus one and the most negative value, where an unsigned or off-by-one comparator picks the wrong branch direction. It uses a negative displacement and a fetch address at the top of memory, where a missing sign extension or a lost carry sends control far away. Linking branches are run both taken and not taken, catching a design that writes register 31 on a failed branch. The jump-and-link case uses an address in a high region, which exposes a target built from the wrong upper bits.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN = 32;
    localparam int OFFW = 16;
    localparam int JFW  = 26;
    localparam int KW   = 4;

    typedef enum logic [KW-1:0] {
        K_SEQ   = 4'd0,
        K_BEQ   = 4'd1,
        K_BNE   = 4'd2,
        K_BLEZ  = 4'd3,
        K_BGTZ  = 4'd4,
        K_BLTZ  = 4'd5,
        K_BGEZ  = 4'd6,
        K_BLTZL = 4'd7,
        K_BGEZL = 4'd8,
        K_JDIR  = 4'd9,
        K_JLNK  = 4'd10,
        K_JREG  = 4'd11
    } flow_kind_e;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] npc;
        logic            taken;
        logic            lwe;
        logic [XLEN-1:0] lval;
    } npc_state_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [KW-1:0] kind,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          redirect,
    output logic          link
);

    logic neg;
    logic zer;
    logic same;

    assign neg  = opa[W-1];
    assign zer  = (opa == '0);
    assign same = (opa == opb);

    always_comb begin
        redirect = 1'b0;
        link     = 1'b0;
        case (kind)
            K_BEQ:   redirect = same;
            K_BNE:   redirect = !same;
            K_BLEZ:  redirect = neg | zer;
            K_BGTZ:  redirect = !neg & !zer;
            K_BLTZ:  redirect = neg;
            K_BGEZ:  redirect = !neg;
            K_BLTZL: begin
                redirect = neg;
                link     = neg;
            end
            K_BGEZL: begin
                redirect = !neg;
                link     = !neg;
            end
            K_JDIR:  redirect = 1'b1;
            K_JLNK:  begin
                redirect = 1'b1;
                link     = 1'b1;
            end
            K_JREG:  redirect = 1'b1;
            default: begin
                redirect = 1'b0;
                link     = 1'b0;
            end
        endcase
    end

    // R7: a link write without a redirect is never produced
    always_comb begin
        a_r7_link_implies_redirect: assert (!link || redirect);
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFFW,
    parameter int JW = JFW
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] boff,
    input  logic [JW-1:0] jfield,
    output logic [W-1:0]  pc4,
    output logic [W-1:0]  br_tgt,
    output logic [W-1:0]  jd_tgt
);

    localparam int SHL   = 2;
    localparam int EXT_W = W - OW - SHL;
    localparam int REG_W = W - JW - SHL;

    logic [W-1:0] disp;

    assign pc4    = pc + {{(W-3){1'b0}}, 3'b100};
    assign disp   = {{EXT_W{boff[OW-1]}}, boff, {SHL{1'b0}}};
    assign br_tgt = pc4 + disp;
    assign jd_tgt = {pc4[W-1 -: REG_W], jfield, {SHL{1'b0}}};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     pc_i,
    input  logic [3:0]      kind_i,
    input  logic [31:0]     opa_i,
    input  logic [31:0]     opb_i,
    input  logic [15:0]     boff_i,
    input  logic [25:0]     jfield_i,
    input  logic [31:0]     jreg_i,
    output logic            out_valid,
    output logic [31:0]     npc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [31:0]     link_val_o
);

    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jd_tgt;
    logic            redirect;
    logic            link;
    npc_state_t      st_d;
    npc_state_t      st_q;

    npc_cond #(.W(XLEN)) u_cond (
        .kind     (kind_i),
        .opa      (opa_i),
        .opb      (opb_i),
        .redirect (redirect),
        .link     (link)
    );

    npc_target #(.W(XLEN), .OW(OFFW), .JW(JFW)) u_tgt (
        .pc     (pc_i),
        .boff   (boff_i),
        .jfield (jfield_i),
        .pc4    (pc4),
        .br_tgt (br_tgt),
        .jd_tgt (jd_tgt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = in_valid;
        st_d.taken = 1'b0;
        st_d.lwe   = 1'b0;
        if (in_valid) begin
            st_d.lval  = pc4;
            st_d.taken = redirect;
            st_d.lwe   = link;
            if (!redirect) begin
                st_d.npc = pc4;
            end else begin
                case (kind_i)
                    K_JDIR, K_JLNK: st_d.npc = jd_tgt;
                    K_JREG:         st_d.npc = jreg_i;
                    default:        st_d.npc = br_tgt;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign npc_o      = st_q.npc;
    assign taken_o    = st_q.taken;
    assign link_we_o  = st_q.lwe;
    assign link_val_o = st_q.lval;

    // R2: idle cycles carry no redirect and no link write
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken_o && !link_we_o));

    // R3: a straight-line result is the next word
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken_o) |-> (npc_o == $past(pc_i) + 32'd4));

    // R4: equality branch decision follows the operands
    a_r4_beq_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(kind_i) == K_BEQ) |-> (taken_o == ($past(opa_i) == $past(opb_i))));

    // R7: link write only on a taken operation
    a_r7_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> taken_o);

    // R8: direct jumps stay in the region of the sequential address
    a_r8_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(kind_i) == K_JDIR || $past(kind_i) == K_JLNK))
        |-> (npc_o[31:28] == ($past(pc_i) + 32'd4) >> 28 && link_we_o == ($past(kind_i) == K_JLNK)));

    // R9: register jump takes the operand unchanged
    a_r9_jreg_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(kind_i) == K_JREG) |-> (npc_o == $past(jreg_i) && taken_o && !link_we_o));

    // R10: return address is the next word
    a_r10_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (link_val_o == $past(pc_i) + 32'd4));

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc_i = '0;
    logic [3:0]  kind_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] boff_i = '0;
    logic [25:0] jfield_i = '0;
    logic [31:0] jreg_i = '0;
    logic        out_valid;
    logic [31:0] npc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [31:0] link_val_o;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] npc;
        logic        tk;
        logic        lwe;
        logic [31:0] lv;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    npc_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .pc_i       (pc_i),
        .kind_i     (kind_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .boff_i     (boff_i),
        .jfield_i   (jfield_i),
        .jreg_i     (jreg_i),
        .out_valid  (out_valid),
        .npc_o      (npc_o),
        .taken_o    (taken_o),
        .link_we_o  (link_we_o),
        .link_val_o (link_val_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] a,
                                   input logic [31:0] b, input logic [15:0] off, input logic [25:0] jf,
                                   input logic [31:0] jr, input string tag);
        exp_t e;
        logic [31:0] seq;
        logic        t;
        logic        l;
        logic [31:0] tgt;
        seq = pc + 32'd4;
        t = 1'b0;
        l = 1'b0;
        tgt = seq + {{14{off[15]}}, off, 2'b00};
        case (k)
            4'd1: t = (a == b);
            4'd2: t = (a != b);
            4'd3: t = ($signed(a) <= 0);
            4'd4: t = ($signed(a) > 0);
            4'd5: t = ($signed(a) < 0);
            4'd6: t = ($signed(a) >= 0);
            4'd7: begin t = ($signed(a) < 0); l = t; end
            4'd8: begin t = ($signed(a) >= 0); l = t; end
            4'd9: begin t = 1'b1; tgt = {seq[31:28], jf, 2'b00}; end
            4'd10: begin t = 1'b1; l = 1'b1; tgt = {seq[31:28], jf, 2'b00}; end
            4'd11: begin t = 1'b1; tgt = jr; end
            default: t = 1'b0;
        endcase
        e.npc = t ? tgt : seq;
        e.tk  = t;
        e.lwe = l;
        e.lv  = seq;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] off, input logic [25:0] jf,
                         input logic [31:0] jr, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        kind_i   = k;
        pc_i     = pc;
        opa_i    = a;
        opb_i    = b;
        boff_i   = off;
        jfield_i = jf;
        jreg_i   = jr;
        q.push_back(model(k, pc, a, b, off, jf, jr, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops the oldest expectation whenever a result is presented
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R2 result without request", 32'(out_valid), 32'd0);
                    end else begin
                        e = q.pop_front();
                        chk(npc_o == e.npc, {e.tag, " npc"}, npc_o, e.npc);
                        chk(taken_o == e.tk, {e.tag, " taken"}, 32'(taken_o), 32'(e.tk));
                        chk(link_we_o == e.lwe, {e.tag, " link_we R7"}, 32'(link_we_o), 32'(e.lwe));
                        chk(link_val_o == e.lv, {e.tag, " link_val R10"}, link_val_o, e.lv);
                    end
                end else begin
                    chk(!taken_o && !link_we_o, "R2 idle quiet", {30'd0, taken_o, link_we_o}, 32'd0);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 50000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && npc_o == 0 && !taken_o && !link_we_o && link_val_o == 0,
            "R1 reset state", npc_o | link_val_o | 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && npc_o == 0, "R1 first cycle after reset", npc_o, 32'd0);

        drive(4'd0,  32'h0000_1000, 32'd0, 32'd0, 16'h0004, 26'd0, 32'd0, "R3 sequential");
        drive(4'd13, 32'h0000_2000, 32'd5, 32'd5, 16'h0010, 26'h3ff, 32'hdead_0000, "R3 unused code");
        drive(4'd0,  32'hFFFF_FFFC, 32'd0, 32'd0, 16'h0000, 26'd0, 32'd0, "R3 wrap at top");
        drive(4'd1,  32'h0000_0100, 32'd7, 32'd7, 16'h0003, 26'd0, 32'd0, "R4 beq equal");
        drive(4'd1,  32'h0000_0100, 32'd7, 32'd8, 16'h0003, 26'd0, 32'd0, "R4 beq differ");
        drive(4'd2,  32'h0000_0200, 32'd1, 32'd2, 16'h0002, 26'd0, 32'd0, "R4 bne differ");
        drive(4'd2,  32'h0000_0200, 32'd9, 32'd9, 16'h0002, 26'd0, 32'd0, "R4 bne equal");
        drive(4'd3,  32'h0000_0300, 32'd0, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 lez zero");
        drive(4'd3,  32'h0000_0300, 32'd5, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 lez positive");
        drive(4'd4,  32'h0000_0400, 32'd0, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 gtz zero");
        drive(4'd4,  32'h0000_0400, 32'h8000_0000, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 gtz most negative");
        drive(4'd4,  32'h0000_0400, 32'd1, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 gtz one");
        drive(4'd5,  32'h0000_0500, 32'hFFFF_FFFF, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 ltz minus one");
        drive(4'd6,  32'h0000_0600, 32'd0, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 gez zero");
        drive(4'd6,  32'h0000_0600, 32'hFFFF_FFFB, 32'd0, 16'h0001, 26'd0, 32'd0, "R5 gez negative");
        drive(4'd1,  32'h0000_8000, 32'd3, 32'd3, 16'hFFFF, 26'd0, 32'd0, "R6 negative offset");
        drive(4'd1,  32'hFFFF_FFF0, 32'd3, 32'd3, 16'h0008, 26'd0, 32'd0, "R6 target wraps");
        drive(4'd7,  32'h0000_0700, 32'hFFFF_FFF0, 32'd0, 16'h0010, 26'd0, 32'd0, "R7 ltz link taken");
        drive(4'd7,  32'h0000_0700, 32'd0, 32'd0, 16'h0010, 26'd0, 32'd0, "R7 ltz link not taken");
        drive(4'd8,  32'h0000_0800, 32'd0, 32'd0, 16'hFFF0, 26'd0, 32'd0, "R7 gez link taken");
        drive(4'd8,  32'h0000_0800, 32'h8000_0000, 32'd0, 16'hFFF0, 26'd0, 32'd0, "R7 gez link not taken");
        drive(4'd9,  32'h1234_5678, 32'd0, 32'd0, 16'd0, 26'h2AB_CDEF, 32'd0, "R8 direct jump");
        drive(4'd10, 32'hF000_0010, 32'd0, 32'd0, 16'd0, 26'h000_0040, 32'd0, "R8 jump and link");
        drive(4'd10, 32'h7FFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h3FF_FFFF, 32'd0, "R8 region from next word");
        drive(4'd11, 32'h0000_0900, 32'd0, 32'd0, 16'd0, 26'd0, 32'h8765_4322, "R9 register jump");
        idle(3);
        drive(4'd11, 32'h0000_0A00, 32'd0, 32'd0, 16'd0, 26'd0, 32'h0040_0000, "R2 after idle");
        idle(3);
        chk(q.size() == 0, "R2 every request answered", 32'(q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule